// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one read or write command for a synchronous DRAM into a run of column addresses, one per clock, and marks the cycles in which data moves. A command supplies the starting column, a burst-length code, the ordering (linear or interleaved), the read latency and a flag that shortens every write to a single word. The block steps through the burst and ends it at its natural length. It also ends it early on a stop request or when a newer command arrives.

Write beats are accepted in the same cycle their column is shown, gated per byte by an input mask sampled in that cycle. Read beats are delayed by the captured latency before the read-valid strobe rises. A per-byte output-enable follows the read-valid strobe, and it is suppressed by an output mask that was sampled two cycles before. The block can sit inside a memory device model or a controller datapath next to the array and the row logic.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, and with no command given, `col_valid`, `rd_valid`, `wr_accept` and `rd_drive` are all zero.
- R2: A command sampled in cycle k shows `start_col` on `col_addr` with `col_valid` high in cycle k+1. `bl_code` gives the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. Codes 100, 101 and 110 give 1 beat.
- R3: In linear order (`order_ilv`=0), beat n addresses the column whose low log2(BL) bits equal (start + n) mod BL. The upper bits are those of the start column.
- R4: In interleaved order (`order_ilv`=1), beat n addresses start XOR n. On a full-page burst `order_ilv` is ignored and linear order is used.
- R5: A full-page burst steps its column by one per cycle, wrapping from 255 to 0, and ends only on a stop request or a new command.
- R6: When `stop` is high in a cycle with `col_valid` high and no command, that beat is still valid and `col_valid` is low in the next cycle. When no burst is running, `stop` has no effect.
- R7: A command arriving during a burst ends the old burst at once. The next cycle shows beat 0 of the new burst. If a command and `stop` arrive in the same cycle, the command wins.
- R8: Each read beat raises `rd_valid` CL-1 cycles after its column cycle, which is CL cycles after the command for beat 0. CL is 2 when `cas_lat3`=0 and 3 when it is 1, and CL is captured with the command. Read beats already issued still produce `rd_valid` after a stop or a truncation.
- R9: With `single_write`=1, a write command gives exactly one beat, whatever the burst-length code. Read bursts keep their programmed length.
- R10: During a write beat, `wr_accept[b]` is high in that same cycle exactly when `in_mask[b]` is low in that cycle. Outside write beats, `wr_accept` is zero.
- R11: `rd_drive[b]` is high exactly when `rd_valid` is high and `out_mask[b]` was low in the cycle two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Start a new burst this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst-length code |
| order_ilv | input | 1 | 1 = interleaved order |
| cas_lat3 | input | 1 | Read latency select: 0 = 2 cycles, 1 = 3 cycles |
| single_write | input | 1 | Force writes to one beat |
| stop | input | 1 | End the running burst after this beat |
| in_mask | input | NB | Per-byte write mask, effective in the same cycle |
| out_mask | input | NB | Per-byte read output mask, effective two cycles later |
| col_valid | output | 1 | A beat is active this cycle |
| col_addr | output | COL_W | Column of the current beat |
| is_write | output | 1 | Current burst is a write |
| wr_accept | output | NB | Per-byte write data taken this cycle |
| rd_valid | output | 1 | Read data is due this cycle |
| rd_drive | output | NB | Per-byte read output enable |

## Verification
Two events can land on the same cycle. A stop request can meet a new command, and the read-valid tail of a truncated read can overlap the first write beats of the command that cut it off. The bench drives a stop together with a command and checks that the new burst starts anyway. It also cuts an 8-beat read with a write, so that `rd_valid` keeps pulsing while `wr_accept` follows the write mask. A behavioural model built from per-cycle schedules of read-valid cycles and mask history judges every output on every clock.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   typedef enum logic [2:0] {
      BLC_ONE  = 3'b000,
      BLC_TWO  = 3'b001,
      BLC_FOUR = 3'b010,
      BLC_EIGHT = 3'b011,
      BLC_PAGE = 3'b111
   } blc_e;

   typedef struct packed {
      logic       page;
      logic [1:0] lg;
   } bl_dec_t;

   function automatic bl_dec_t bl_decode(input logic [2:0] code);
      bl_dec_t d;
      d = '0;
      case (code)
         BLC_TWO:   d.lg = 2'd1;
         BLC_FOUR:  d.lg = 2'd2;
         BLC_EIGHT: d.lg = 2'd3;
         BLC_PAGE:  d.page = 1'b1;
         default:   d.lg = 2'd0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] lin_col;
   logic [COL_W-1:0] sum;

   always_comb begin
      sum     = start + cnt;
      lin_col = (start & ~mask) | (sum & mask);
   end

   generate
      if (ILV_EN) begin : g_ilv
         logic [COL_W-1:0] xor_col;
         always_comb begin
            xor_col = start ^ (cnt & mask);
            col     = ilv ? xor_col : lin_col;
         end
      end else begin : g_lin
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign col = lin_col;
      end
   endgenerate
endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl
   import sdr_burst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       bl_code,
   input  logic             order_ilv,
   input  logic             cas_lat3,
   input  logic             single_write,
   input  logic             stop,
   output logic             act_q,
   output logic             wr_q,
   output logic             cl3_q,
   output logic             ilv_q,
   output logic [COL_W-1:0] start_q,
   output logic [COL_W-1:0] cnt_q,
   output logic [COL_W-1:0] mask_q
);
   bl_dec_t          dec;
   logic             one_wr;
   logic             new_page;
   logic [COL_W-1:0] new_mask;
   logic             page_q;
   logic             last;

   always_comb begin
      dec      = bl_decode(bl_code);
      one_wr   = cmd_write & single_write;
      new_page = dec.page & ~one_wr;
      if (one_wr)
         new_mask = '0;
      else if (dec.page)
         new_mask = '1;
      else
         new_mask = COL_W'((1 << dec.lg) - 1);
      last = ~page_q & (cnt_q == mask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         cl3_q   <= 1'b0;
         ilv_q   <= 1'b0;
         page_q  <= 1'b0;
         start_q <= '0;
         cnt_q   <= '0;
         mask_q  <= '0;
      end else if (cmd_valid) begin
         act_q   <= 1'b1;
         wr_q    <= cmd_write;
         cl3_q   <= cas_lat3;
         ilv_q   <= order_ilv & ~new_page;
         page_q  <= new_page;
         start_q <= start_col;
         cnt_q   <= '0;
         mask_q  <= new_mask;
      end else if (act_q) begin
         if (stop || last)
            act_q <= 1'b0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
   parameter int CL_LO = 2,
   parameter int CL_HI = 3,
   parameter int NB    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat_in,
   input  logic          hi_sel,
   input  logic [NB-1:0] out_mask,
   output logic          valid_out,
   output logic [NB-1:0] drive
);
   localparam int DEPTH  = CL_HI - 1;
   localparam int IDX_HI = 0;
   localparam int IDX_LO = CL_HI - CL_LO;

   logic [DEPTH-1:0] stg_q;
   logic [DEPTH-1:0] stg_d;
   logic [NB-1:0]    om_d1;
   logic [NB-1:0]    om_d2;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stg
         logic ins;
         assign ins = beat_in & ((hi_sel && i == IDX_HI) || (!hi_sel && i == IDX_LO));
         if (i == 0) begin : g_head
            assign stg_d[i] = ins;
         end else begin : g_body
            assign stg_d[i] = stg_q[i-1] | ins;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
         om_d1 <= '0;
         om_d2 <= '0;
      end else begin
         stg_q <= stg_d;
         om_d1 <= out_mask;
         om_d2 <= om_d1;
      end
   end

   assign valid_out = stg_q[DEPTH-1];
   assign drive     = {NB{valid_out}} & ~om_d2;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
   parameter int COL_W  = 8,
   parameter int NB     = 2,
   parameter int CL_LO  = 2,
   parameter int CL_HI  = 3,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       bl_code,
   input  logic             order_ilv,
   input  logic             cas_lat3,
   input  logic             single_write,
   input  logic             stop,
   input  logic [NB-1:0]    in_mask,
   input  logic [NB-1:0]    out_mask,
   output logic             col_valid,
   output logic [COL_W-1:0] col_addr,
   output logic             is_write,
   output logic [NB-1:0]    wr_accept,
   output logic             rd_valid,
   output logic [NB-1:0]    rd_drive
);
   generate
      if (COL_W < 3) begin : g_bad_col
         $error("COL_W must hold an 8-beat burst");
      end
      if (CL_LO < 2 || CL_HI < CL_LO) begin : g_bad_cl
         $error("latency parameters out of range");
      end
      if (NB < 1) begin : g_bad_nb
         $error("NB must be at least 1");
      end
   endgenerate

   logic             act_q, wr_q, cl3_q, ilv_q;
   logic [COL_W-1:0] start_q, cnt_q, mask_q;

   sdr_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .start_col(start_col), .bl_code(bl_code), .order_ilv(order_ilv),
      .cas_lat3(cas_lat3), .single_write(single_write), .stop(stop),
      .act_q(act_q), .wr_q(wr_q), .cl3_q(cl3_q), .ilv_q(ilv_q),
      .start_q(start_q), .cnt_q(cnt_q), .mask_q(mask_q)
   );

   sdr_col_gen #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_col (
      .start(start_q), .cnt(cnt_q), .mask(mask_q), .ilv(ilv_q), .col(col_addr)
   );

   sdr_lat_pipe #(.CL_LO(CL_LO), .CL_HI(CL_HI), .NB(NB)) u_pipe (
      .clk(clk), .rst_n(rst_n), .beat_in(act_q & ~wr_q), .hi_sel(cl3_q),
      .out_mask(out_mask), .valid_out(rd_valid), .drive(rd_drive)
   );

   assign col_valid = act_q;
   assign is_write  = wr_q;
   assign wr_accept = {NB{act_q & wr_q}} & ~in_mask;
endmodule

// File: rtl/sdr_burst_chk.sv
module sdr_burst_chk #(
   parameter int COL_W = 8,
   parameter int NB    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_write,
   input logic [COL_W-1:0] start_col,
   input logic [2:0]       bl_code,
   input logic             single_write,
   input logic             stop,
   input logic             col_valid,
   input logic [COL_W-1:0] col_addr,
   input logic             is_write,
   input logic [NB-1:0]    wr_accept,
   input logic             rd_valid,
   input logic [NB-1:0]    rd_drive
);
   logic pg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pg_q <= 1'b0;
      else if (cmd_valid)
         pg_q <= (bl_code == 3'b111) && !(cmd_write && single_write);
   end

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> col_valid && col_addr == $past(start_col));

   p_cmd_beats_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && stop |=> col_valid);

   p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && pg_q && !stop && !cmd_valid
      |=> col_valid && col_addr == COL_W'($past(col_addr) + 1'b1));

   p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && stop && !cmd_valid |=> !col_valid);

   p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && $past(cmd_valid && cmd_write && single_write) && !cmd_valid
      |=> !col_valid);

   p_rd_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(col_valid && !is_write) || $past(col_valid && !is_write, 2));

   p_wr_in_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      |wr_accept |-> col_valid && is_write);

   p_drive_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      |rd_drive |-> rd_valid);
endmodule

bind sdr_burst_seq sdr_burst_chk #(.COL_W(COL_W), .NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
   .start_col(start_col), .bl_code(bl_code), .single_write(single_write),
   .stop(stop), .col_valid(col_valid), .col_addr(col_addr), .is_write(is_write),
   .wr_accept(wr_accept), .rd_valid(rd_valid), .rd_drive(rd_drive)
);

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;
   localparam int CLK_PERIOD = 10;
   localparam int COL_W = 8;
   localparam int NB = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 0, cmd_write = 0, order_ilv = 0, cas_lat3 = 0;
   logic single_write = 0, stop = 0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0] bl_code = '0;
   logic [NB-1:0] in_mask = '0, out_mask = '0;
   logic col_valid, is_write, rd_valid;
   logic [COL_W-1:0] col_addr;
   logic [NB-1:0] wr_accept, rd_drive;

   int nvec = 0;
   int nerr = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdr_burst_seq i_sdr_burst_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .start_col(start_col), .bl_code(bl_code), .order_ilv(order_ilv),
      .cas_lat3(cas_lat3), .single_write(single_write), .stop(stop),
      .in_mask(in_mask), .out_mask(out_mask), .col_valid(col_valid),
      .col_addr(col_addr), .is_write(is_write), .wr_accept(wr_accept),
      .rd_valid(rd_valid), .rd_drive(rd_drive)
   );

   // behavioural reference state
   int cyc = 0;
   bit rdv[int];
   int omh[int];
   bit m_act = 0, m_wr = 0, m_ilv = 0, m_page = 0;
   int m_start = 0, m_n = 0, m_len = 1, m_cl = 2;

   function automatic int exp_col();
      int base;
      if (m_ilv) return m_start ^ m_n;
      base = m_start - (m_start % m_len);
      return (base + ((m_start % m_len) + m_n) % m_len) % 256;
   endfunction

   task automatic cmp(string tag, string field, int got, int exp);
      nvec++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, field, got, exp, cyc);
      end
   endtask

   task automatic check(string tag);
      int ev, em;
      cmp(tag, "col_valid", int'(col_valid), int'(m_act));
      if (m_act) begin
         cmp(tag, "col_addr", int'(col_addr), exp_col());
         cmp(tag, "is_write", int'(is_write), int'(m_wr));
      end
      cmp(tag, "wr_accept", int'(wr_accept), (m_act && m_wr) ? int'(~in_mask) & 3 : 0);
      ev = rdv.exists(cyc) ? 1 : 0;
      em = omh.exists(cyc - 2) ? omh[cyc - 2] : 0;
      cmp(tag, "rd_valid", int'(rd_valid), ev);
      cmp(tag, "rd_drive", int'(rd_drive), ev ? (~em & 3) : 0);
   endtask

   task automatic model_update();
      omh[cyc] = int'(out_mask);
      if (m_act && !m_wr) rdv[cyc + m_cl - 1] = 1;
      if (cmd_valid) begin
         m_act = 1; m_wr = cmd_write; m_start = int'(start_col); m_n = 0;
         m_cl = cas_lat3 ? 3 : 2;
         case (bl_code)
            3'b001: m_len = 2;
            3'b010: m_len = 4;
            3'b011: m_len = 8;
            3'b111: m_len = 256;
            default: m_len = 1;
         endcase
         m_page = (bl_code == 3'b111);
         if (cmd_write && single_write) begin m_len = 1; m_page = 0; end
         m_ilv = order_ilv && !m_page;
      end else if (m_act) begin
         if (stop) m_act = 0;
         else begin
            m_n++;
            if (!m_page && m_n == m_len) m_act = 0;
         end
      end
      cyc++;
   endtask

   task automatic tick(string tag);
      #1;
      check(tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic idle(int n, string tag);
      cmd_valid = 0; stop = 0;
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic issue(bit w, int col, int bl, bit ilv, bit cl3, string tag);
      cmd_valid = 1; cmd_write = w; start_col = COL_W'(col); bl_code = 3'(bl);
      order_ilv = ilv; cas_lat3 = cl3;
      tick(tag);
      cmd_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: quiet after reset
      idle(3, "R1");
      // R2 R3: linear BL4 read, CL2, start in the middle of its block
      issue(0, 8'h0E, 2, 0, 0, "R2");
      idle(6, "R3");
      // R4 R8: interleaved BL8 read, CL3
      issue(0, 8'h35, 3, 1, 1, "R4");
      idle(12, "R8");
      // R10: write BL8 with per-beat input masks
      issue(1, 8'hF9, 3, 0, 0, "R10");
      for (int i = 0; i < 9; i++) begin
         in_mask = NB'(i % 4);
         tick("R10");
      end
      in_mask = '0;
      // R9: single-word writes, reads keep length
      single_write = 1;
      issue(1, 8'h42, 3, 0, 0, "R9");
      idle(3, "R9");
      issue(0, 8'h42, 2, 0, 1, "R9");
      idle(7, "R9");
      single_write = 0;
      // R5 R6: full page from near the top, wraps, then stop
      issue(0, 8'hFC, 7, 0, 0, "R5");
      idle(300, "R5");
      stop = 1; tick("R6");
      idle(5, "R6");
      // R4: interleave ignored on full page
      issue(1, 8'h13, 7, 1, 0, "R4");
      idle(20, "R4");
      stop = 1; tick("R6");
      idle(3, "R6");
      // R2: short and reserved codes
      issue(0, 8'h07, 0, 0, 0, "R2");
      idle(3, "R2");
      issue(1, 8'h07, 1, 1, 0, "R2");
      idle(3, "R2");
      issue(0, 8'h21, 5, 0, 0, "R2");
      idle(4, "R2");
      // R7 R8: read cut by write, tail of read still valid
      issue(0, 8'h60, 3, 0, 1, "R7");
      idle(2, "R7");
      in_mask = 2'b10;
      issue(1, 8'h80, 2, 0, 0, "R7");
      idle(5, "R8");
      in_mask = '0;
      // R7: command and stop in the same cycle
      issue(0, 8'h10, 3, 0, 0, "R7");
      idle(2, "R7");
      stop = 1;
      issue(0, 8'hA4, 2, 1, 0, "R7");
      stop = 0;
      idle(6, "R7");
      // R11: output mask toggling during a read
      issue(0, 8'h58, 3, 0, 1, "R11");
      for (int i = 0; i < 12; i++) begin
         out_mask = NB'(i % 3);
         tick("R11");
      end
      out_mask = '0;
      // R6: stop with nothing running
      stop = 1; tick("R6"); tick("R6");
      idle(3, "R6");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule